// File: doc/BRIEF.md
# Stop-Mode Wake and Reset Controller

This block supervises a low-power stop state for a small processor core. A one-cycle stop strobe turns the core clock off. Two events can end the stop state. The first is a level change on any of the eight wake-port pins, in either direction, measured against the levels captured at stop entry. This event emits a single-cycle wake interrupt and then forces a full core reset. The reset is held for a fixed 2^16-cycle oscillator stabilization window. The second event is an ordinary interrupt request. It does not reset the core. It only keeps the clock off for a programmable stabilization window before execution resumes.

Each port pin first passes through a synchronizer and then a stable-for-N-cycles noise filter, so short glitches never count as edges. In run mode a pin can also act as an external interrupt: a filtered falling edge on an enabled pin sets that pin's pending flag. Two sticky status flags record how the last stop exit happened. They survive the generated reset and clear when a 1 is written to them. Power-on reset uses the same 2^16-cycle hold as a reset-wake.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After `rstN` is released, `coreRst` stays high and `coreClkEn` stays low for exactly 65536 clock cycles, and then the core runs (`coreRst`=0, `coreClkEn`=1).
- R2: A `stopReq` strobe in run mode drives `coreClkEn` low from the next cycle on, without asserting `coreRst`.
- R3: In stop mode, a filtered change on any port pin, rising or falling, relative to the levels at stop entry raises `wakeIrq` for exactly one cycle.
- R4: `coreRst` rises on the cycle after the `wakeIrq` pulse and stays high for exactly 65536 cycles. Then `coreClkEn` returns to 1.
- R5: Outside stop mode, port edges never produce `wakeIrq` and never assert `coreRst`.
- R6: A level change that lasts fewer than FILT_CYCLES (default 3) synchronized cycles is ignored: in stop mode it causes no wake.
- R7: `irqWakeReq` in stop mode with no port change keeps `coreClkEn` low for 2^n cycles, with n = 8, 11, 13, 16 for `stabSel` = 0, 1, 2, 3. It causes no `wakeIrq` and no `coreRst`.
- R8: In run mode, a filtered falling edge on pin i with `intEn[i]`=1 sets `intPend[i]`. Disabled pins and rising edges set nothing. A 1 on `pendClr[i]` clears `intPend[i]`.
- R9: A reset-wake sets `stsResetWake` and clears `stsIrqWake`. An interrupt-wake does the reverse. Both flags survive `coreRst`. `statusClr` bit 0 clears `stsResetWake` and bit 1 clears `stsIrqWake`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on oscillator clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| portPins | input | 8 | Raw wake-port pin levels |
| intEn | input | 8 | Per-pin external interrupt enable |
| pendClr | input | 8 | Write-1-to-clear for the pending flags |
| stopReq | input | 1 | One-cycle stop entry strobe |
| irqWakeReq | input | 1 | Ordinary enabled interrupt request that wakes from stop |
| stabSel | input | 2 | Selects the interrupt-wake stabilization length |
| statusClr | input | 2 | Write-1-to-clear: bit 0 reset-wake flag, bit 1 interrupt-wake flag |
| coreRst | output | 1 | Core reset, active high |
| coreClkEn | output | 1 | Core clock gate enable |
| wakeIrq | output | 1 | One-cycle non-vectored wake interrupt |
| intPend | output | 8 | Per-pin interrupt pending flags |
| stsResetWake | output | 1 | Last stop exit was a reset-wake |
| stsIrqWake | output | 1 | Last stop exit was an interrupt-wake |

## Verification
The in-line assertions check the following on every cycle:
- the clock gate falls right after a stop strobe;
- every wake pulse is one cycle long, is preceded by a detected port change, and is followed at once by reset;
- reset never rises without a wake pulse;
- pending flags are set only for pins that were enabled;
- the two status flags are never set together.

Only the bench scenarios show:
- the exact lengths of the 65536-cycle reset hold and the three programmable interrupt-wake holds;
- that glitches shorter than the filter window are swallowed;
- that random edge patterns in run mode give the pending flags a reference model predicts;
- that the status flags persist across the generated reset.

// File: rtl/swk_pkg.sv
package swk_pkg;

  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_STOP    = 3'd1,
    ST_WAKE    = 3'd2,
    ST_RSTHOLD = 3'd3,
    ST_IRQHOLD = 3'd4
  } swkState_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic captureRef;
    logic loadRst;
    logic loadIrq;
    logic countDown;
    logic setRstFlag;
    logic setIrqFlag;
    logic runMode;
  } swkStrobe_t;

  // interrupt-wake stabilization exponent per select code
  function automatic int unsigned stabLog2(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8;
      2'd1:    return 11;
      2'd2:    return 13;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/swk_datapath.sv
module swk_datapath
  import swk_pkg::*;
#(
  parameter int PINS          = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int FILT_CYCLES   = 3,
  parameter int RST_WAIT_LOG2 = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PINS-1:0] portPins,
  input  logic [PINS-1:0] intEn,
  input  logic [PINS-1:0] pendClr,
  input  logic [1:0]      stabSel,
  input  logic [1:0]      statusClr,
  input  swkStrobe_t      strobe,
  output logic            portChanged,
  output logic            cntZero,
  output logic [PINS-1:0] intPend,
  output logic            stsResetWake,
  output logic            stsIrqWake
);

  localparam int FCW = $clog2(FILT_CYCLES + 1);
  localparam int CW  = (RST_WAIT_LOG2 > 16) ? RST_WAIT_LOG2 : 16;
  localparam logic [CW-1:0] ONES = {CW{1'b1}};
  localparam logic [CW-1:0] RST_LOAD = ONES >> (CW - RST_WAIT_LOG2);

  logic [PINS-1:0] syncQ [SYNC_STAGES];
  logic [PINS-1:0] syncLast;
  logic [PINS-1:0] filtQ;
  logic [PINS-1:0] filtPrev;
  logic [PINS-1:0] stopRef;
  logic [CW-1:0]   waitCnt;
  logic [CW-1:0]   irqLoad;
  logic [PINS-1:0] fallSeen;

  // input synchronizer chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
    end else begin
      syncQ[0] <= portPins;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end
  assign syncLast = syncQ[SYNC_STAGES-1];

  // per-pin stable-for-N noise filter
  for (genvar p = 0; p < PINS; p++) begin : g_filt
    logic [FCW-1:0] runLen;
    logic           filtBit;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        runLen  <= '0;
        filtBit <= 1'b0;
      end else if (syncLast[p] == filtBit) begin
        runLen <= '0;
      end else if (runLen == FCW'(FILT_CYCLES - 1)) begin
        runLen  <= '0;
        filtBit <= syncLast[p];
      end else begin
        runLen <= runLen + 1'b1;
      end
    end
    assign filtQ[p] = filtBit;
  end

  // stop-entry reference and change detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopRef  <= '0;
      filtPrev <= '0;
    end else begin
      filtPrev <= filtQ;
      if (strobe.captureRef) stopRef <= filtQ;
    end
  end
  assign portChanged = |(filtQ ^ stopRef);

  // stabilization counter
  assign irqLoad = ONES >> (CW - int'(stabLog2(stabSel)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  waitCnt <= RST_LOAD;
    else if (strobe.loadRst)    waitCnt <= RST_LOAD;
    else if (strobe.loadIrq)    waitCnt <= irqLoad;
    else if (strobe.countDown)  waitCnt <= waitCnt - 1'b1;
  end
  assign cntZero = (waitCnt == '0);

  // external interrupt pending flags
  assign fallSeen = filtPrev & ~filtQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) intPend <= '0;
    else       intPend <= (intPend & ~pendClr) |
                          (strobe.runMode ? (intEn & fallSeen) : '0);
  end

  // sticky exit-cause status, reset only by power-on reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stsResetWake <= 1'b0;
      stsIrqWake   <= 1'b0;
    end else if (strobe.setRstFlag) begin
      stsResetWake <= 1'b1;
      stsIrqWake   <= 1'b0;
    end else if (strobe.setIrqFlag) begin
      stsResetWake <= 1'b0;
      stsIrqWake   <= 1'b1;
    end else begin
      if (statusClr[0]) stsResetWake <= 1'b0;
      if (statusClr[1]) stsIrqWake   <= 1'b0;
    end
  end

  // R8: a pending bit only appears for a pin enabled in the prior cycle
  assert_pend_enabled_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((intPend & ~$past(intPend) & ~$past(intEn)) == '0));

  // R9: the two exit-cause flags are exclusive
  assert_status_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stsResetWake, stsIrqWake}));

endmodule

// File: rtl/swk_control.sv
module swk_control
  import swk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stopReq,
  input  logic       irqWakeReq,
  input  logic       portChanged,
  input  logic       cntZero,
  output swkStrobe_t strobe,
  output logic       coreRst,
  output logic       coreClkEn,
  output logic       wakeIrq
);

  swkState_e state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    strobe.runMode = (state == ST_RUN);
    unique case (state)
      ST_RUN: begin
        if (stopReq) begin
          stateNext         = ST_STOP;
          strobe.captureRef = 1'b1;
        end
      end
      ST_STOP: begin
        if (portChanged) begin
          stateNext = ST_WAKE;
        end else if (irqWakeReq) begin
          stateNext         = ST_IRQHOLD;
          strobe.loadIrq    = 1'b1;
          strobe.setIrqFlag = 1'b1;
        end
      end
      ST_WAKE: begin
        stateNext         = ST_RSTHOLD;
        strobe.loadRst    = 1'b1;
        strobe.setRstFlag = 1'b1;
      end
      ST_RSTHOLD, ST_IRQHOLD: begin
        if (cntZero) stateNext = ST_RUN;
        else         strobe.countDown = 1'b1;
      end
      default: stateNext = ST_RSTHOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RSTHOLD;
    else       state <= stateNext;
  end

  assign coreRst   = (state == ST_RSTHOLD);
  assign coreClkEn = (state == ST_RUN);
  assign wakeIrq   = (state == ST_WAKE);

  // R2: clock gated on the cycle after a stop strobe, core not reset
  assert_gate_after_stop_R2: assert property (@(posedge clk) disable iff (!rstN)
    (coreClkEn && stopReq) |=> (!coreClkEn && !coreRst));

  // R3: a wake pulse only follows a detected port change
  assert_wake_from_port_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeIrq) |-> $past(portChanged));

  // R4: one-cycle wake pulse, reset on the following cycle
  assert_reset_after_wake_R4: assert property (@(posedge clk) disable iff (!rstN)
    wakeIrq |=> (!wakeIrq && coreRst));

  // R5: the generated reset never rises without a wake pulse
  assert_reset_needs_wake_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreRst) |-> $past(wakeIrq));

endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
  import swk_pkg::*;
#(
  parameter int PINS          = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int FILT_CYCLES   = 3,
  parameter int RST_WAIT_LOG2 = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PINS-1:0] portPins,
  input  logic [PINS-1:0] intEn,
  input  logic [PINS-1:0] pendClr,
  input  logic            stopReq,
  input  logic            irqWakeReq,
  input  logic [1:0]      stabSel,
  input  logic [1:0]      statusClr,
  output logic            coreRst,
  output logic            coreClkEn,
  output logic            wakeIrq,
  output logic [PINS-1:0] intPend,
  output logic            stsResetWake,
  output logic            stsIrqWake
);

  swkStrobe_t strobe;
  logic       portChanged;
  logic       cntZero;

  swk_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .stopReq    (stopReq),
    .irqWakeReq (irqWakeReq),
    .portChanged(portChanged),
    .cntZero    (cntZero),
    .strobe     (strobe),
    .coreRst    (coreRst),
    .coreClkEn  (coreClkEn),
    .wakeIrq    (wakeIrq)
  );

  swk_datapath #(
    .PINS         (PINS),
    .SYNC_STAGES  (SYNC_STAGES),
    .FILT_CYCLES  (FILT_CYCLES),
    .RST_WAIT_LOG2(RST_WAIT_LOG2)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .portPins    (portPins),
    .intEn       (intEn),
    .pendClr     (pendClr),
    .stabSel     (stabSel),
    .statusClr   (statusClr),
    .strobe      (strobe),
    .portChanged (portChanged),
    .cntZero     (cntZero),
    .intPend     (intPend),
    .stsResetWake(stsResetWake),
    .stsIrqWake  (stsIrqWake)
  );

endmodule

// File: tb/stop_wake_ctrl_bench.sv
`timescale 1ns/1ps
module stop_wake_ctrl_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] portPins, intEn, pendClr;
  logic       stopReq, irqWakeReq;
  logic [1:0] stabSel, statusClr;
  logic       coreRst, coreClkEn, wakeIrq;
  logic [7:0] intPend;
  logic       stsResetWake, stsIrqWake;

  always #2.5 clk = ~clk;

  stop_wake_ctrl u_stop_wake_ctrl (
    .clk(clk), .rstN(rstN), .portPins(portPins), .intEn(intEn),
    .pendClr(pendClr), .stopReq(stopReq), .irqWakeReq(irqWakeReq),
    .stabSel(stabSel), .statusClr(statusClr), .coreRst(coreRst),
    .coreClkEn(coreClkEn), .wakeIrq(wakeIrq), .intPend(intPend),
    .stsResetWake(stsResetWake), .stsIrqWake(stsIrqWake)
  );

  int  testsRun = 0;
  int  testsFailed = 0;
  int  wakeSeen = 0;
  bit  finished = 0;

  always @(negedge clk) if (rstN && wakeIrq) wakeSeen++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expHold(input logic [1:0] sel);
    case (sel)
      2'd0: return 256;
      2'd1: return 2048;
      2'd2: return 8192;
      default: return 65536;
    endcase
  endfunction

  function automatic logic [7:0] expPend(input logic [7:0] cur, input logic [7:0] en,
                                         input logic [7:0] oldP, input logic [7:0] newP);
    return cur | (en & oldP & ~newP);
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enterStop();
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
  endtask

  task automatic irqWake(input logic [1:0] sel);
    int n;
    stabSel = sel;
    enterStop();
    cyc(3);
    irqWakeReq = 1'b1;
    @(negedge clk);
    irqWakeReq = 1'b0;
    n = 0;
    while (!coreClkEn && n < 70000) begin
      if (coreRst) n = 99999;
      n++;
      @(negedge clk);
    end
    check(n == expHold(sel), "R7 interrupt-wake hold length", n, expHold(sel));
    check(stsIrqWake && !stsResetWake, "R9 interrupt-wake status", {stsResetWake, stsIrqWake}, 1);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    rstN = 1'b0; portPins = 8'hFF; intEn = '0; pendClr = '0;
    stopReq = 1'b0; irqWakeReq = 1'b0; stabSel = 2'd0; statusClr = '0;
    cyc(5);
    check(coreRst && !coreClkEn && !wakeIrq, "R1 reset state outputs",
          {coreRst, coreClkEn, wakeIrq}, 3'b100);
    check(intPend == 8'h00 && !stsResetWake && !stsIrqWake, "R9 reset state flags",
          {intPend, stsResetWake, stsIrqWake}, 0);

    // R1: power-on stabilization hold
    begin
      int n = 0;
      rstN = 1'b1;
      while (coreRst && n < 70000) begin n++; @(negedge clk); end
      check(n == 65536, "R1 power-on hold length", n, 65536);
      check(coreClkEn, "R1 core runs after hold", coreClkEn, 1);
    end

    // R5/R8: random edges in run mode
    begin
      logic [7:0] prevP = 8'hFF;
      logic [7:0] model = 8'h00;
      for (int i = 0; i < 60; i++) begin
        logic [7:0] clr = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
        logic [7:0] np  = 8'($urandom);
        logic [7:0] en  = 8'($urandom);
        if (i == 0) begin np = 8'h00; en = 8'hFF; end      // directed: every pin falls
        if (i == 1) begin np = 8'hFF; en = 8'hFF; clr = 8'hFF; end // rising only, after clear
        if (i == 59) np = 8'hFF;
        pendClr = clr;
        @(negedge clk);
        pendClr = '0;
        model = model & ~clr;
        intEn = en; portPins = np;
        cyc(9);
        model = expPend(model, en, prevP, np);
        prevP = np;
        check(intPend == model, "R8 pending flags", intPend, model);
        check(!coreRst && coreClkEn, "R5 run mode unaffected by edges", coreRst, 0);
      end
      check(wakeSeen == 0, "R5 no wake outside stop", wakeSeen, 0);
      pendClr = 8'hFF; @(negedge clk); pendClr = '0; intEn = '0;
      cyc(2);
      check(intPend == 8'h00, "R8 write-1 clear all", intPend, 0);
    end

    // R2/R6: stop entry and glitch rejection
    enterStop();
    check(!coreClkEn && !coreRst, "R2 clock gated after stop strobe",
          {coreClkEn, coreRst}, 0);
    portPins[3] = 1'b0;
    cyc(2);
    portPins[3] = 1'b1;
    cyc(12);
    check(wakeSeen == 0, "R6 short glitch ignored", wakeSeen, 0);
    check(!coreClkEn && !coreRst, "R6 still stopped after glitch", coreClkEn, 0);
    irqWakeReq = 1'b1; @(negedge clk); irqWakeReq = 1'b0;
    while (!coreClkEn) @(negedge clk);

    // R7: programmable interrupt-wake holds
    irqWake(2'd0);
    irqWake(2'd1);
    irqWake(2'd2);
    check(wakeSeen == 0, "R7 no wake pulse on interrupt exit", wakeSeen, 0);
    statusClr = 2'b10; @(negedge clk); statusClr = '0;
    check(!stsIrqWake, "R9 clear interrupt-wake flag", stsIrqWake, 0);

    // R3/R4/R9: reset-wake on a rising edge of pin 0
    portPins = 8'hFE;
    cyc(10);
    enterStop();
    cyc(3);
    portPins = 8'hFF;
    begin
      int w = 0;
      int n = 0;
      while (!wakeIrq && w < 30) begin w++; @(negedge clk); end
      check(wakeIrq && !coreRst, "R3 wake pulse on port edge", wakeIrq, 1);
      @(negedge clk);
      check(!wakeIrq && coreRst, "R4 reset follows one-cycle pulse",
            {wakeIrq, coreRst}, 2'b01);
      while (coreRst && n < 70000) begin n++; @(negedge clk); end
      check(n == 65536, "R4 reset-wake hold length", n, 65536);
      check(coreClkEn, "R4 clock back on after hold", coreClkEn, 1);
      check(wakeSeen == 1, "R3 exactly one wake pulse", wakeSeen, 1);
      check(stsResetWake && !stsIrqWake, "R9 reset-wake flag survives reset",
            {stsResetWake, stsIrqWake}, 2'b10);
    end
    statusClr = 2'b01; @(negedge clk); statusClr = '0;
    check(!stsResetWake, "R9 clear reset-wake flag", stsResetWake, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL R1 watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule